// File: doc/BRIEF.md
# Freezable DC-Offset Removal Filter

This block sits behind a decimation stage and removes the DC component from a stream of signed 24-bit audio samples that belong to three channel paths. Samples arrive one at a time with a valid strobe and a channel index. For every channel the block keeps its own running estimate of the DC level and subtracts it from each sample of that channel. The result is clipped to the 24-bit range and comes out one cycle later with the channel index.

The estimate is a leaky integrator with a wide fractional accumulator. Each channel's estimate follows its input only while that channel's enable is high. When the enable is low, the estimate stops moving but is still subtracted. This gives a simple calibration procedure: run with the enable high until the estimate settles on the system offset, then drop the enable so that the offset stays locked and keeps being removed. Channels 0 and 1 share one enable and channel 2 has its own.

Top module: `dc_trim_filter`

## Requirements
- R1: For each accepted sample the output is the input minus the channel's estimate as it stood before that sample, saturated to 24 bits (R5).
- R2: While a channel's enable is high, each of its samples x moves the accumulator by ((x scaled by 2^FRAC_W) - acc) arithmetically shifted right by K. The estimate is the accumulator shifted right by FRAC_W (floor).
- R3: While a channel's enable is low, its samples leave its estimate unchanged, and that held value is still subtracted from later samples.
- R4: Channel indices 0 and 1 are governed by `en_pair` and index 2 by `en_solo`. A sample on one channel never changes another channel's estimate.
- R5: Results above 8388607 come out as 8388607, and results below -8388608 come out as -8388608.
- R6: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. Cycles without `in_valid` leave all estimates unchanged.
- R7: `out_chan` carries the index of the sample that produced `out_data`.
- R8: A synchronous active-low reset clears every estimate to zero and clears `out_valid`.
- R9: After an enabled channel settles on a constant input and is then disabled, that constant input comes out within ±1 of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 2 | Channel index of the input sample (0 to 2) |
| in_data | input | 24 | Signed input sample |
| en_pair | input | 1 | Tracking enable for channels 0 and 1 |
| en_solo | input | 1 | Tracking enable for channel 2 |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 2 | Channel index of the output sample |
| out_data | output | 24 | Signed offset-corrected, saturated sample |

## Verification
The assertions assume that the channel index is below three whenever `in_valid` is high. Index 3 has no estimator, so the hold and subtraction properties say nothing about it. The assertions also assume that reset is sampled only on clock edges, so that one cycle of reset is enough to clear every estimate. The stimulus drives only indices 0 to 2, and it changes inputs and enables on the falling edge so that each sample sees stable enables. It also holds reset low for whole clock cycles.

// File: rtl/dcf_pkg.sv
// Shared constants and helpers for the DC-offset removal filter.
// Assumes channel indices start at zero and that the shared-enable group
// takes the lowest indices.
package dcf_pkg;
    localparam int unsigned DEF_DW     = 24;
    localparam int unsigned DEF_NCH    = 3;
    localparam int unsigned DEF_PAIR_N = 2;

    // True when channel idx is controlled by the shared enable.
    function automatic logic in_pair_group(input int unsigned idx, input int unsigned pair_n);
        return idx < pair_n;
    endfunction
endpackage

// File: rtl/dcf_estimator.sv
// One channel's DC estimate: a leaky integrator with FRAC_W fractional bits.
// On upd the accumulator moves by ((x << FRAC_W) - acc) >>> K. Otherwise it holds.
// Assumes K <= FRAC_W + DW so that the step is well defined.
module dcf_estimator #(
    parameter int unsigned DW     = 24,
    parameter int unsigned FRAC_W = 12,
    parameter int unsigned K      = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic signed [DW-1:0] x,
    output logic signed [DW-1:0] est
);
    localparam int unsigned SW = DW + FRAC_W;   // stored accumulator width
    localparam int unsigned AW = SW + 1;        // width for the difference

    logic signed [SW-1:0] acc;
    logic signed [AW-1:0] x_ext, acc_ext, diff, step, nxt;

    // Compute the next accumulator value from the sample and current state.
    always_comb begin
        x_ext   = {x[DW-1], x, {FRAC_W{1'b0}}};
        acc_ext = {acc[SW-1], acc};
        diff    = x_ext - acc_ext;
        step    = diff >>> K;
        nxt     = acc_ext + step;
    end

    // Accumulator register: clear on reset, advance only when updating.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (upd) acc <= nxt[SW-1:0];
    end

    assign est = acc[SW-1:FRAC_W];
endmodule

// File: rtl/dcf_subsat.sv
// Combinational subtract with saturation to the signed DW-bit range.
// Assumes both operands are two's complement of width DW.
module dcf_subsat #(
    parameter int unsigned DW = 24
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] y
);
    logic signed [DW:0] wide;

    // Subtract one bit wider, then clip when the top two bits disagree.
    always_comb begin
        wide = {a[DW-1], a} - {b[DW-1], b};
        if (wide[DW] != wide[DW-1])
            y = wide[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else
            y = wide[DW-1:0];
    end
endmodule

// File: rtl/dc_trim_filter.sv
// Multi-channel DC-offset removal with freezable estimates.
// Each valid sample has its channel's held estimate removed and is clipped,
// with one cycle of latency. If that channel is enabled, the estimate is then
// updated. Channels below PAIR_N share en_pair and the rest use en_solo.
// Assumes in_chan < NCH whenever in_valid is high.
module dc_trim_filter
    import dcf_pkg::*;
#(
    parameter int unsigned DW     = DEF_DW,
    parameter int unsigned NCH    = DEF_NCH,
    parameter int unsigned PAIR_N = DEF_PAIR_N,
    parameter int unsigned K      = 10,
    parameter int unsigned FRAC_W = 12,
    localparam int unsigned CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [CW-1:0]        in_chan,
    input  logic signed [DW-1:0] in_data,
    input  logic                 en_pair,
    input  logic                 en_solo,
    output logic                 out_valid,
    output logic [CW-1:0]        out_chan,
    output logic signed [DW-1:0] out_data
);
    logic signed [DW-1:0] est_arr [NCH];
    logic [NCH*DW-1:0]    est_all;
    logic [NCH-1:0]       upd;
    logic signed [DW-1:0] est_sel;
    logic signed [DW-1:0] trimmed;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic en_g;
        // Route this channel to its enable group.
        assign en_g = in_pair_group(g, PAIR_N) ? en_pair : en_solo;
        assign upd[g] = in_valid && (in_chan == CW'(g)) && en_g;
        assign est_all[g*DW +: DW] = est_arr[g];

        dcf_estimator #(.DW(DW), .FRAC_W(FRAC_W), .K(K)) u_est (
            .clk  (clk),
            .rst_n(rst_n),
            .upd  (upd[g]),
            .x    (in_data),
            .est  (est_arr[g])
        );
    end

    // Pick the estimate of the addressed channel (zero for unused indices).
    always_comb begin
        est_sel = '0;
        for (int i = 0; i < NCH; i++)
            if (in_chan == CW'(i)) est_sel = est_arr[i];
    end

    dcf_subsat #(.DW(DW)) u_sub (
        .a(in_data),
        .b(est_sel),
        .y(trimmed)
    );

    // Output register: strobe follows the input by one cycle, data on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_chan <= in_chan;
                out_data <= trimmed;
            end
        end
    end
endmodule

// File: rtl/dcf_checker.sv
// Property checker for dc_trim_filter, attached by bind below.
// Assumes in_chan < NCH on valid samples.
module dcf_checker #(
    parameter int unsigned DW     = 24,
    parameter int unsigned NCH    = 3,
    parameter int unsigned PAIR_N = 2,
    parameter int unsigned CW     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [CW-1:0]        in_chan,
    input logic signed [DW-1:0] in_data,
    input logic                 en_pair,
    input logic                 en_solo,
    input logic                 out_valid,
    input logic [CW-1:0]        out_chan,
    input logic signed [DW-1:0] out_data,
    input logic [NCH*DW-1:0]    est_all
);
    logic signed [DW-1:0] ref_est;
    logic signed [DW+1:0] ref_diff;
    logic signed [DW-1:0] ref_out;
    logic                 chan_held;

    // Independent expectation: addressed estimate, wide difference, clip.
    always_comb begin
        ref_est = '0;
        for (int i = 0; i < NCH; i++)
            if (in_chan == CW'(i)) ref_est = est_all[i*DW +: DW];
        ref_diff = DW'(0) + in_data - ref_est;
        ref_diff = {{2{in_data[DW-1]}}, in_data} - {{2{ref_est[DW-1]}}, ref_est};
        if (ref_diff > $signed({3'b000, {(DW-1){1'b1}}}))
            ref_out = {1'b0, {(DW-1){1'b1}}};
        else if (ref_diff < -$signed({3'b001, {(DW-1){1'b0}}}))
            ref_out = {1'b1, {(DW-1){1'b0}}};
        else
            ref_out = ref_diff[DW-1:0];
        chan_held = (32'(in_chan) < PAIR_N) ? !en_pair : !en_solo;
    end

    a_r1_trim_value: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_data == $past(ref_out));
    a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chan_held) |=> $stable(est_all));
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(est_all)));
    a_r7_chan_echo: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_chan == $past(in_chan));
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (est_all == '0 && !out_valid));
endmodule

bind dc_trim_filter dcf_checker #(.DW(DW), .NCH(NCH), .PAIR_N(PAIR_N), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_chan  (in_chan),
    .in_data  (in_data),
    .en_pair  (en_pair),
    .en_solo  (en_solo),
    .out_valid(out_valid),
    .out_chan (out_chan),
    .out_data (out_data),
    .est_all  (est_all)
);

// File: tb/tb_dc_trim_filter.sv
// Self-checking bench: vector table from reset, then directed scenarios.
module tb_dc_trim_filter;
    localparam int DW  = 24;
    localparam int KT  = 3;
    localparam int FT  = 6;
    localparam longint MAXV = 8388607;
    localparam longint MINV = -8388608;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_chan = '0;
    logic signed [DW-1:0] in_data = '0;
    logic en_pair = 1'b0;
    logic en_solo = 1'b0;
    logic out_valid;
    logic [1:0] out_chan;
    logic signed [DW-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    longint acc [3];

    dc_trim_filter #(.DW(DW), .NCH(3), .PAIR_N(2), .K(KT), .FRAC_W(FT)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_data(in_data), .en_pair(en_pair), .en_solo(en_solo),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Table: channel, sample, expected output with all estimates at zero.
    typedef struct packed { logic [1:0] ch; logic signed [31:0] x; logic signed [31:0] y; } vec_t;
    localparam vec_t TBL [6] = '{
        '{2'd0, 32'sd1234,     32'sd1234},
        '{2'd1, -32'sd77,      -32'sd77},
        '{2'd2, 32'sd8388607,  32'sd8388607},
        '{2'd0, -32'sd8388608, -32'sd8388608},
        '{2'd2, 32'sd0,        32'sd0},
        '{2'd1, 32'sd555555,   32'sd555555}
    };

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint clip(input longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    // Drive one sample, check the registered result, advance the model.
    task automatic send(input int ch, input longint x, input string req);
        longint exp;
        bit en;
        @(negedge clk);
        in_valid = 1'b1; in_chan = 2'(ch); in_data = DW'(x);
        exp = clip(x - (acc[ch] >>> FT));
        en  = (ch < 2) ? en_pair : en_solo;
        if (en) acc[ch] = acc[ch] + (((x <<< FT) - acc[ch]) >>> KT);
        @(posedge clk); #2;
        check({req, " valid(R6)"}, longint'(out_valid), 1);
        check({req, " chan(R7)"}, longint'(out_chan), ch);
        check(req, longint'(out_data), exp);
    endtask

    task automatic idle(input int n);
        @(negedge clk); in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            check("R6 idle no output", longint'(out_valid), 0);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 3; i++) acc[i] = 0;
        in_valid = 1'b1;  // valid during reset must not leak out (R8)
        repeat (3) @(posedge clk);
        #2 check("R8 reset out_valid", longint'(out_valid), 0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;

        // Table walk: disabled and freshly reset, so output equals input (R8, R3).
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_chan = TBL[i].ch; in_data = DW'(TBL[i].x);
            @(posedge clk); #2;
            check("R8 table zero estimate", longint'(out_data), longint'(TBL[i].y));
            check("R7 table chan", longint'(out_chan), longint'(TBL[i].ch));
        end
        idle(3);

        // R2/R4: pair enabled, solo disabled; channel 2 must stay untouched.
        en_pair = 1'b1;
        for (int i = 0; i < 60; i++) begin
            send(0, 1000, "R2 ch0 track");
            send(1, -300, "R4 ch1 shares pair enable");
            send(2, 500, "R4 ch2 solo held");
        end
        check("R4 ch2 estimate stayed zero", acc[2], 0);

        // R9/R3: freeze, then constant offset comes out near zero.
        en_pair = 1'b0;
        send(0, 1000, "R9 calibrated ch0");
        check("R9 residual within 1", (out_data >= -1 && out_data <= 1) ? 1 : 0, 1);
        send(1, -300, "R9 calibrated ch1");
        check("R9 residual ch1 within 1", (out_data >= -1 && out_data <= 1) ? 1 : 0, 1);
        for (int i = 0; i < 5; i++) send(0, 1000 + 37 * i, "R3 frozen subtract");
        send(0, 1000, "R3 estimate unchanged after frozen samples");
        check("R3 still within 1", (out_data >= -1 && out_data <= 1) ? 1 : 0, 1);

        // R5: learn a large positive offset, then drive the opposite extreme.
        en_pair = 1'b1;
        for (int i = 0; i < 150; i++) send(0, 8000000, "R2 ch0 large learn");
        en_pair = 1'b0;
        send(0, -8000000, "R5 negative clip");
        check("R5 negative rail", longint'(out_data), MINV);

        en_solo = 1'b1;
        for (int i = 0; i < 150; i++) send(2, -8000000, "R2 ch2 large learn");
        en_solo = 1'b0;
        send(2, 8000000, "R5 positive clip");
        check("R5 positive rail", longint'(out_data), MAXV);
        idle(4);

        // R8: reset mid-run clears all learned offsets.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 3; i++) acc[i] = 0;
        send(0, 4321, "R8 ch0 cleared");
        check("R8 ch0 passes unchanged", longint'(out_data), 4321);
        send(2, -4321, "R8 ch2 cleared");
        check("R8 ch2 passes unchanged", longint'(out_data), -4321);
        idle(2);

        summary();
    end
endmodule